// File: doc/BRIEF.md
# Multiplexed DAC and Sample-Hold Refresh Sequencer

The block takes a frame of 128 eight-bit setpoints over a byte-wide valid/ready input and stores it. It then refreshes 128 analog drive channels through one quad parallel DAC whose four outputs feed four 32-channel sample-and-hold amplifier arrays. Each setpoint passes through an internal 256-entry square-root table that maps it to a 12-bit DAC code. The four arrays share one enable line, and their 5-bit channel address rides on the low five DAC data pins. For this reason, DAC loading and amplifier sampling take turns in separate phases on one shared bus. The block drives 17 output pins: 12 bus, 2 DAC output select, 1 write strobe, 1 amplifier enable and 1 power-up control.

Channel n belongs to amplifier slot n[6:2] and to DAC output n[1:0]. For each slot, the block writes the four DAC outputs in ascending order and holds the bus for a settle interval. It then places the slot number on the bus and pulses the shared enable, so the four arrays sample together. The sequence repeats for all 32 slots, then a one-cycle frame-done pulse is raised and the next frame may be received. A start command raises the power-up output. No transfer happens while that output is low.

The states are as follows. OFF is left on `start_i`, going to RECV. RECV goes to WRITE when the 128th byte is accepted. WRITE always moves to GAP. GAP ends after the write period; it goes to WRITE if more lanes of the slot remain, otherwise to SETTLE. SETTLE goes to SAMPLE once the settle count ends. SAMPLE, when its count ends, goes to WRITE for the next slot or to DONE after slot 31. DONE always returns to RECV.

Top module: `mirror_refresh_seq`

## Requirements
- R1: After reset, `pwr_en_o`, `in_ready_o`, `dac_wr_o`, `amp_en_o` and `frame_done_o` are 0 and `dac_data_o` is 0. They stay so, with input bytes ignored, until `start_i` is seen.
- R2: `start_i` in OFF raises `pwr_en_o` on the next edge, and it then stays high. `dac_wr_o`, `amp_en_o` and `in_ready_o` are never high while `pwr_en_o` is low.
- R3: In RECV, `in_ready_o` is 1. The k-th accepted byte (valid and ready at the same edge, k = 0..127) is the setpoint of channel k.
- R4: The DAC code for setpoint v is floor(sqrt(v * 65793)), where 65793 = (4096*4096-1)/255. So 0 maps to 0 and 255 maps to 4095.
- R5: Channels are written in ascending order 0..127. Each write is a one-cycle high pulse of `dac_wr_o`, with `dac_sel_o` = n[1:0] and `dac_data_o` = the code of channel n.
- R6: Consecutive writes within one slot start exactly WR_PERIOD cycles apart (default 435, i.e. under 230 kHz at 100 MHz).
- R7: After the four writes of slot g, `amp_en_o` rises exactly WR_PERIOD+SETTLE_CYC cycles after the last write. It stays high for EN_CYC cycles, and `dac_data_o` equals g (bits 11:5 zero) while it is high.
- R8: `dac_wr_o` and `amp_en_o` are never high together, and `dac_data_o` is stable while `amp_en_o` is high.
- R9: `frame_done_o` is a one-cycle pulse in the cycle right after the last enable cycle of slot 31. `in_ready_o` is 1 in the following cycle.
- R10: From the first write of a frame until its `frame_done_o`, `in_ready_o` is 0, so bytes offered then are not taken.
- R11: A frame takes 32*(4*WR_PERIOD+SETTLE_CYC+EN_CYC) cycles from its first write to `frame_done_o`. With the defaults this is 57920 cycles, within the 100000 cycles of 1 ms at 100 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start command; raises the power-up control |
| in_data_i | input | 8 | Setpoint byte |
| in_valid_i | input | 1 | Setpoint byte valid |
| in_ready_o | output | 1 | Block can accept a byte |
| pwr_en_o | output | 1 | Power-up control |
| dac_data_o | output | 12 | Shared bus: DAC code, or amplifier slot on bits 4:0 |
| dac_sel_o | output | 2 | DAC output select |
| dac_wr_o | output | 1 | DAC write strobe, active high |
| amp_en_o | output | 1 | Shared amplifier sample enable, active high |
| frame_done_o | output | 1 | One-cycle pulse at the end of a frame refresh |

## Verification
The first frame is a ramp of even values with channel 0 at 0 and channel 127 at 255. It exposes lane or slot swaps, because every channel carries a distinct value, and it hits both ends of the square-root table. The second frame uses a scrambled pattern with valid gaps on the input. This separates correct byte-to-channel indexing from simple counting of cycles. Junk bytes are offered before the start command and throughout the first refresh; any byte taken at the wrong time shows up as a mismatch in the channel order. Strobe spacing, settle distance, enable width and total frame length are measured from the outputs against the parameter formulas.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_RECV,
        ST_WRITE,
        ST_GAP,
        ST_SETTLE,
        ST_SAMPLE,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/mrs_sqrt_lut.sv
module mrs_sqrt_lut #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 12
) (
    input  logic [IN_W-1:0]  idx_i,
    output logic [OUT_W-1:0] code_o
);
    localparam int DEPTH = 1 << IN_W;
    localparam longint unsigned SCALE =
        ((64'd1 << (2 * OUT_W)) - 64'd1) / ((64'd1 << IN_W) - 64'd1);

    // Largest r with r*r <= x, built bit by bit from the top.
    function automatic logic [OUT_W-1:0] root_of(input longint unsigned x);
        logic [OUT_W-1:0] r;
        logic [OUT_W-1:0] cand;
        longint unsigned  t;
        r = '0;
        for (int b = OUT_W - 1; b >= 0; b--) begin
            cand    = r;
            cand[b] = 1'b1;
            t       = 64'(cand);
            if (t * t <= x) r = cand;
        end
        return r;
    endfunction

    logic [OUT_W-1:0] tbl [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        assign tbl[i] = root_of(64'(i) * SCALE);
    end

    assign code_o = tbl[idx_i];

endmodule

// File: rtl/mrs_frame_buf.sv
module mrs_frame_buf #(
    parameter int DEPTH = 128,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [W-1:0]  rdata_o
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/mrs_seq_fsm.sv
module mrs_seq_fsm
    import mrs_pkg::*;
#(
    parameter int NUM_CH     = 128,
    parameter int LANES      = 4,
    parameter int WR_PERIOD  = 435,
    parameter int SETTLE_CYC = 50,
    parameter int EN_CYC     = 20,
    localparam int CH_W      = $clog2(NUM_CH),
    localparam int LANE_W    = $clog2(LANES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            in_valid_i,
    output logic            in_ready_o,
    output logic            buf_we_o,
    output logic [CH_W-1:0] ch_o,
    output logic            wr_o,
    output logic            en_o,
    output logic            data_phase_o,
    output logic            addr_phase_o,
    output logic            pwr_o,
    output logic            done_o
);
    localparam int MAX_A   = (WR_PERIOD > SETTLE_CYC) ? WR_PERIOD : SETTLE_CYC;
    localparam int CNT_MAX = (MAX_A > EN_CYC) ? MAX_A : EN_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CH_W-1:0]   LAST_CH   = CH_W'(NUM_CH - 1);
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

    seq_state_e       state, nxt;
    logic [CNT_W-1:0] cnt;
    logic [CH_W-1:0]  ch;
    logic             pwr;
    logic             cnt_zero;

    assign cnt_zero = (cnt == '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:    if (start_i) nxt = ST_RECV;
            ST_RECV:   if (in_valid_i && ch == LAST_CH) nxt = ST_WRITE;
            ST_WRITE:  nxt = ST_GAP;
            ST_GAP:    if (cnt_zero)
                           nxt = (ch[LANE_W-1:0] == LAST_LANE) ? ST_SETTLE : ST_WRITE;
            ST_SETTLE: if (cnt_zero) nxt = ST_SAMPLE;
            ST_SAMPLE: if (cnt_zero) nxt = (ch == LAST_CH) ? ST_DONE : ST_WRITE;
            ST_DONE:   nxt = ST_RECV;
            default:   nxt = ST_OFF;
        endcase
    end

    // Channel index, phase timer and power-up flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch  <= '0;
            cnt <= '0;
            pwr <= 1'b0;
        end else begin
            unique case (state)
                ST_OFF:    if (start_i) pwr <= 1'b1;
                ST_RECV:   if (in_valid_i) ch <= ch + 1'b1;
                ST_WRITE:  cnt <= CNT_W'(WR_PERIOD - 2);
                ST_GAP: begin
                    if (!cnt_zero)                         cnt <= cnt - 1'b1;
                    else if (ch[LANE_W-1:0] != LAST_LANE)  ch  <= ch + 1'b1;
                    else                                   cnt <= CNT_W'(SETTLE_CYC - 1);
                end
                ST_SETTLE: begin
                    if (!cnt_zero) cnt <= cnt - 1'b1;
                    else           cnt <= CNT_W'(EN_CYC - 1);
                end
                ST_SAMPLE: begin
                    if (!cnt_zero) cnt <= cnt - 1'b1;
                    else           ch  <= ch + 1'b1;
                end
                ST_DONE:   cnt <= '0;
                default:   cnt <= '0;
            endcase
        end
    end

    // Moore outputs
    always_comb begin
        in_ready_o   = 1'b0;
        buf_we_o     = 1'b0;
        wr_o         = 1'b0;
        en_o         = 1'b0;
        data_phase_o = 1'b0;
        addr_phase_o = 1'b0;
        done_o       = 1'b0;
        unique case (state)
            ST_OFF:    ;
            ST_RECV: begin
                in_ready_o = 1'b1;
                buf_we_o   = in_valid_i;
            end
            ST_WRITE: begin
                wr_o         = 1'b1;
                data_phase_o = 1'b1;
            end
            ST_GAP:    data_phase_o = 1'b1;
            ST_SETTLE: addr_phase_o = 1'b1;
            ST_SAMPLE: begin
                en_o         = 1'b1;
                addr_phase_o = 1'b1;
            end
            ST_DONE:   done_o = 1'b1;
            default:   ;
        endcase
    end

    assign ch_o  = ch;
    assign pwr_o = pwr;

endmodule

// File: rtl/mirror_refresh_seq.sv
module mirror_refresh_seq #(
    parameter int NUM_CH     = 128,
    parameter int LANES      = 4,
    parameter int IN_W       = 8,
    parameter int DAC_W      = 12,
    parameter int WR_PERIOD  = 435,
    parameter int SETTLE_CYC = 50,
    parameter int EN_CYC     = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [IN_W-1:0]          in_data_i,
    input  logic                     in_valid_i,
    output logic                     in_ready_o,
    output logic                     pwr_en_o,
    output logic [DAC_W-1:0]         dac_data_o,
    output logic [$clog2(LANES)-1:0] dac_sel_o,
    output logic                     dac_wr_o,
    output logic                     amp_en_o,
    output logic                     frame_done_o
);
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int LANE_W = $clog2(LANES);
    localparam int GRP_W  = CH_W - LANE_W;

    logic [CH_W-1:0]  ch;
    logic             buf_we;
    logic             data_phase, addr_phase;
    logic [IN_W-1:0]  setpoint;
    logic [DAC_W-1:0] code;
    logic [GRP_W-1:0] slot;

    mrs_seq_fsm #(
        .NUM_CH(NUM_CH), .LANES(LANES), .WR_PERIOD(WR_PERIOD),
        .SETTLE_CYC(SETTLE_CYC), .EN_CYC(EN_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .in_valid_i(in_valid_i),
        .in_ready_o(in_ready_o), .buf_we_o(buf_we), .ch_o(ch),
        .wr_o(dac_wr_o), .en_o(amp_en_o), .data_phase_o(data_phase),
        .addr_phase_o(addr_phase), .pwr_o(pwr_en_o), .done_o(frame_done_o)
    );

    mrs_frame_buf #(.DEPTH(NUM_CH), .W(IN_W)) u_buf (
        .clk(clk), .we_i(buf_we), .waddr_i(ch), .wdata_i(in_data_i),
        .raddr_i(ch), .rdata_o(setpoint)
    );

    mrs_sqrt_lut #(.IN_W(IN_W), .OUT_W(DAC_W)) u_lut (
        .idx_i(setpoint), .code_o(code)
    );

    assign slot = ch[CH_W-1:LANE_W];

    // Shared bus: DAC code in the data phase, slot number in the address phase
    always_comb begin
        if (data_phase)      dac_data_o = code;
        else if (addr_phase) dac_data_o = {{(DAC_W-GRP_W){1'b0}}, slot};
        else                 dac_data_o = '0;
    end

    assign dac_sel_o = data_phase ? ch[LANE_W-1:0] : '0;

endmodule

// File: rtl/mrs_checker.sv
module mrs_checker #(
    parameter int DAC_W = 12,
    parameter int GRP_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwr,
    input logic             ready,
    input logic             wr,
    input logic             en,
    input logic             done,
    input logic [DAC_W-1:0] bus
);
    a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && en));

    a_r2_power_first: assert property (@(posedge clk) disable iff (!rst_n)
        (wr || en || ready) |-> pwr);

    a_r2_power_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        pwr |=> pwr);

    a_r7_slot_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (bus[DAC_W-1:GRP_W] == '0));

    a_r8_bus_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en)) |-> $stable(bus));

    a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !wr);

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(en));

    a_r10_no_rx_in_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        (wr || en) |-> !ready);

endmodule

bind mirror_refresh_seq mrs_checker #(
    .DAC_W(DAC_W), .GRP_W($clog2(NUM_CH) - $clog2(LANES))
) u_chk (
    .clk(clk), .rst_n(rst_n), .pwr(pwr_en_o), .ready(in_ready_o),
    .wr(dac_wr_o), .en(amp_en_o), .done(frame_done_o), .bus(dac_data_o)
);

// File: tb/mirror_refresh_seq_tb.sv
`timescale 1ns/1ps
module mirror_refresh_seq_tb;
    localparam int WP = 435, SC = 50, EC = 20;
    localparam int FRAME_CYC = 32 * (4 * WP + SC + EC);

    logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
    logic [7:0] in_data_i = 8'h00;
    logic in_valid_i = 1'b0;
    logic in_ready_o, pwr_en_o, dac_wr_o, amp_en_o, frame_done_o;
    logic [11:0] dac_data_o;
    logic [1:0]  dac_sel_o;

    int checks = 0, errors = 0, cyc = 0;
    bit finished = 1'b0;

    mirror_refresh_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .in_data_i(in_data_i),
        .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .pwr_en_o(pwr_en_o),
        .dac_data_o(dac_data_o), .dac_sel_o(dac_sel_o), .dac_wr_o(dac_wr_o),
        .amp_en_o(amp_en_o), .frame_done_o(frame_done_o)
    );

    always #5 clk = ~clk;

    function automatic int pat(int f, int k);
        if (f == 0) return (k == 127) ? 255 : (k * 2) % 256;
        return (k * 37 + 11) % 256;
    endfunction

    function automatic int exp_code(int v);
        real scale;
        scale = real'(4096 * 4096 - 1) / 255.0;
        return $rtoi($sqrt(real'(v) * scale));
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Reference model state
    int rx_f = 0, rx_k = 0, wr_k = 0, frames = 0;
    int last_wr = 0, first_wr = 0, en_start = 0;
    bit prev_en = 1'b0, prev_done = 1'b0, refreshing = 1'b0;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !finished) begin
            check(1'b0, "watchdog", cyc, 190000);
            summary();
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (!pwr_en_o && (dac_wr_o || amp_en_o || in_ready_o))
                check(1'b0, "R2 drive before power", 1, 0);
            if (dac_wr_o && amp_en_o) check(1'b0, "R8 write/enable overlap", 1, 0);
            if (refreshing && in_ready_o) check(1'b0, "R10 ready during refresh", 1, 0);
            if (prev_done) check(in_ready_o == 1'b1, "R9 ready after done", int'(in_ready_o), 1);
            if (in_valid_i && in_ready_o) begin
                check(int'(in_data_i) == pat(rx_f, rx_k), "R3 accepted byte order",
                      int'(in_data_i), pat(rx_f, rx_k));
                rx_k++;
                if (rx_k == 128) begin rx_k = 0; rx_f++; end
            end
            if (dac_wr_o) begin
                if (wr_k == 0) begin first_wr = cyc; refreshing = 1'b1; end
                check(int'(dac_sel_o) == wr_k % 4, "R5 output select",
                      int'(dac_sel_o), wr_k % 4);
                check(int'(dac_data_o) == exp_code(pat(frames, wr_k)), "R4 R5 DAC code",
                      int'(dac_data_o), exp_code(pat(frames, wr_k)));
                if (wr_k % 4 != 0)
                    check(cyc - last_wr == WP, "R6 write spacing", cyc - last_wr, WP);
                last_wr = cyc;
                wr_k++;
            end
            if (amp_en_o && !prev_en) begin
                check(int'(dac_data_o) == wr_k / 4 - 1, "R7 slot on bus",
                      int'(dac_data_o), wr_k / 4 - 1);
                check(wr_k % 4 == 0 && wr_k > 0, "R7 four writes before enable", wr_k, 4);
                check(cyc - last_wr == WP + SC, "R7 settle distance", cyc - last_wr, WP + SC);
                en_start = cyc;
            end
            if (amp_en_o && prev_en)
                if (int'(dac_data_o) != wr_k / 4 - 1)
                    check(1'b0, "R8 bus stable in enable", int'(dac_data_o), wr_k / 4 - 1);
            if (!amp_en_o && prev_en)
                check(cyc - en_start == EC, "R7 enable width", cyc - en_start, EC);
            if (frame_done_o) begin
                check(prev_en, "R9 done follows last enable", int'(prev_en), 1);
                check(wr_k == 128, "R5 all channels written", wr_k, 128);
                check(cyc - first_wr == FRAME_CYC, "R11 frame length", cyc - first_wr, FRAME_CYC);
                check((cyc - first_wr) * 10 <= 1000000, "R11 within 1 ms",
                      (cyc - first_wr) * 10, 1000000);
                wr_k = 0; refreshing = 1'b0; frames++;
            end
            if (prev_done) check(!frame_done_o, "R9 done is one cycle", int'(frame_done_o), 0);
            prev_en   = amp_en_o;
            prev_done = frame_done_o;
        end
    end

    task automatic send_frame(int f, bit gaps);
        int k = 0;
        int n = 0;
        bit hs;
        while (k < 128) begin
            in_valid_i = !(gaps && (n % 3 == 2));
            in_data_i  = 8'(pat(f, k));
            @(negedge clk);
            hs = in_valid_i && in_ready_o;
            @(posedge clk); #1;
            if (hs) k++;
            n++;
        end
        in_valid_i = 1'b0;
    endtask

    task automatic offer_junk_until_done();
        in_valid_i = 1'b1;
        in_data_i  = 8'hA5;
        do @(negedge clk); while (!frame_done_o);
        @(posedge clk); #1;
        in_valid_i = 1'b0;
    endtask

    initial begin
        in_valid_i = 1'b1;
        in_data_i  = 8'hA5;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: idle state, junk offered, no start yet
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(!pwr_en_o, "R1 power low", int'(pwr_en_o), 0);
            check(!in_ready_o && !dac_wr_o && !amp_en_o && !frame_done_o,
                  "R1 strobes low", int'({in_ready_o, dac_wr_o, amp_en_o, frame_done_o}), 0);
            check(dac_data_o == 12'd0, "R1 bus idle", int'(dac_data_o), 0);
        end
        @(posedge clk); #1;
        start_i = 1'b1;
        in_valid_i = 1'b0;
        @(posedge clk); #1;
        start_i = 1'b0;
        @(negedge clk);
        check(pwr_en_o, "R2 power after start", int'(pwr_en_o), 1);
        check(in_ready_o, "R3 ready in receive", int'(in_ready_o), 1);
        @(posedge clk); #1;
        send_frame(0, 1'b0);
        offer_junk_until_done();
        check(pwr_en_o, "R2 power stays high", int'(pwr_en_o), 1);
        send_frame(1, 1'b1);
        do @(negedge clk); while (!frame_done_o);
        repeat (3) @(negedge clk);
        check(frames == 2, "R9 two frames completed", frames, 2);
        check(rx_f == 2 && rx_k == 0, "R10 no extra bytes taken", rx_f * 128 + rx_k, 256);
        summary();
    end

endmodule